// File: doc/BRIEF.md
# Scatter-Gather Buffer Chain Walker

This block sits in front of a card data engine and tells it which memory buffer to move next. In single mode it offers one contiguous buffer, taken from the base and size registers, and then reports completion. In chain mode it starts with a first buffer whose link word, base and size were written into registers by software. Each time the engine reports that a buffer is consumed, the walker reads the next three-word descriptor from memory. It keeps walking until it reaches a link word whose continue flag is clear.

Software sets up the list base, the first link word, the base and the size. It then starts the walk by writing the control register. Writing zero to the control register stops the walk at any point. Before a buffer is offered, its base and size are checked for alignment. A violation raises an error flag and ends the walk.

Top module: `sgw_top`

## Requirements
- R1: While reset is held and after it is released, `buf_req`, `mem_req`, `xfer_done` and `err` are low.
- R2: The register addresses are: 0 for control (bit 0 run, bit 1 chain mode), 1 for list base, 2 for link word, 3 for base, 4 for size. A control write with run set and chain clear offers one buffer. That buffer carries the base and size registers and has `buf_last` high. It issues no memory read.
- R3: In chain mode, the first buffer is offered from the preloaded base, size and link registers. No memory read happens before that buffer is consumed.
- R4: Link word layout: bits 15:0 give the byte offset of the next descriptor from the list base. Bit 31 means continue, bit 30 means reload size, and bit 29 means reload base. The next descriptor is read as three words, in the order link, base, size, at list base + offset, +4 and +8.
- R5: Each descriptor word read keeps `mem_req` high and `mem_addr` unchanged until `mem_valid` is seen.
- R6: A fetched base or size replaces the current one only if the matching reload flag is set in the link word that pointed to that descriptor. Otherwise the previous value is kept.
- R7: When a buffer's link word has bit 31 clear, the walker shows `buf_last` high for it. After it is consumed, the walker raises `xfer_done` and fetches nothing more.
- R8: For a non-last buffer, a base that is not a multiple of 4, or a size that is not a multiple of 2^BLK_LOG2, is an error. In that case no request is made, `err` goes high, and the walk stops. `err` clears on the next start.
- R9: A last buffer is checked for base alignment only; any size is accepted.
- R10: A control write of zero stops the walker within one cycle. `buf_req` and `mem_req` drop, and no `xfer_done` follows.
- R11: `xfer_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_valid | input | 1 | Read data valid, completes the current word |
| mem_data | input | 32 | Read data |
| buf_req | output | 1 | A buffer is offered to the data engine |
| buf_addr | output | 32 | Offered buffer base address |
| buf_size | output | 32 | Offered buffer size in bytes |
| buf_last | output | 1 | Offered buffer ends the transfer |
| buf_done | input | 1 | Data engine has consumed the offered buffer |
| xfer_done | output | 1 | Transfer complete pulse |
| err | output | 1 | Alignment error, walk stopped |

## Verification
The assertions assume a few things about the inputs. `buf_done` is raised only while `buf_req` is high. `mem_valid` arrives only while `mem_req` is high. Register writes other than to the control register are not made in the middle of a walk. The stimulus follows these rules: the consumer pulses `buf_done` for one cycle after it sees a request, and the memory model answers each request after one wait cycle. Registers are preloaded only while the walker is idle.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int DW = 32;
    localparam int OFS_W = 16;
    localparam int LNK_CONT = 31;
    localparam int LNK_RSIZE = 30;
    localparam int LNK_RBASE = 29;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_LBASE = 3'd1;
    localparam logic [2:0] REG_LINK = 3'd2;
    localparam logic [2:0] REG_BASE = 3'd3;
    localparam logic [2:0] REG_SIZE = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_FETCH = 2'd2
    } walk_st_e;

    typedef struct packed {
        walk_st_e         st;
        logic [DW-1:0]    link;
        logic [DW-1:0]    base;
        logic [DW-1:0]    size;
        logic [DW-1:0]    lbase;
        logic             chain;
        logic             err;
        logic             done;
        logic             upd_base;
        logic             upd_size;
    } walk_reg_t;

    typedef struct packed {
        logic             busy;
        logic [1:0]       idx;
        logic [DW-1:0]    addr;
    } fetch_reg_t;
endpackage

// File: rtl/sgw_align.sv
module sgw_align #(
    parameter int BLK_LOG2 = 5
) (
    input  logic [31:0] base,
    input  logic [31:0] size,
    input  logic        is_last,
    output logic        bad
);
    localparam int GW = (BLK_LOG2 < 1) ? 1 : BLK_LOG2;

    always_comb begin
        bad = (base[1:0] != 2'b00);
        if (!is_last && (size[GW-1:0] != '0)) begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/sgw_fetch.sv
module sgw_fetch
    import sgw_pkg::*;
#(
    parameter int WORDS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] start_addr,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_data,
    output logic          word_valid,
    output logic [1:0]    word_idx,
    output logic [DW-1:0] word_data
);
    localparam logic [1:0] LAST_IDX = 2'(WORDS - 1);

    fetch_reg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (abort) begin
            f_d.busy = 1'b0;
        end else if (start) begin
            f_d.busy = 1'b1;
            f_d.idx  = 2'd0;
            f_d.addr = start_addr;
        end else if (f_q.busy && mem_valid) begin
            f_d.idx  = f_q.idx + 2'd1;
            f_d.addr = f_q.addr + 32'd4;
            if (f_q.idx == LAST_IDX) begin
                f_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req    = f_q.busy;
    assign mem_addr   = f_q.addr;
    assign word_valid = f_q.busy && mem_valid && !abort;
    assign word_idx   = f_q.idx;
    assign word_data  = mem_data;

    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !abort && !start) |=> (mem_req && $stable(mem_addr)));

    // R4
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !abort && !start && (f_q.idx != LAST_IDX))
            |=> (mem_addr == $past(mem_addr) + 32'd4));
endmodule

// File: rtl/sgw_top.sv
module sgw_top
    import sgw_pkg::*;
#(
    parameter int BLK_LOG2 = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_data,
    output logic        buf_req,
    output logic [31:0] buf_addr,
    output logic [31:0] buf_size,
    output logic        buf_last,
    input  logic        buf_done,
    output logic        xfer_done,
    output logic        err
);
    walk_reg_t w_d, w_q;

    logic          is_last;
    logic          bad;
    logic          f_start;
    logic          f_abort;
    logic [DW-1:0] f_addr;
    logic          wv;
    logic [1:0]    widx;
    logic [DW-1:0] wdat;

    assign is_last = !w_q.chain || !w_q.link[LNK_CONT];
    assign f_addr  = w_q.lbase + {{(DW-OFS_W){1'b0}}, w_q.link[OFS_W-1:0]};

    sgw_align #(.BLK_LOG2(BLK_LOG2)) i_align (
        .base    (w_q.base),
        .size    (w_q.size),
        .is_last (is_last),
        .bad     (bad)
    );

    sgw_fetch #(.WORDS(3)) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (f_start),
        .abort      (f_abort),
        .start_addr (f_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_valid  (mem_valid),
        .mem_data   (mem_data),
        .word_valid (wv),
        .word_idx   (widx),
        .word_data  (wdat)
    );

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        f_start  = 1'b0;
        f_abort  = 1'b0;

        unique case (w_q.st)
            ST_SERVE: begin
                if (bad) begin
                    w_d.err = 1'b1;
                    w_d.st  = ST_IDLE;
                end else if (buf_done) begin
                    if (is_last) begin
                        w_d.done = 1'b1;
                        w_d.st   = ST_IDLE;
                    end else begin
                        f_start      = 1'b1;
                        w_d.upd_base = w_q.link[LNK_RBASE];
                        w_d.upd_size = w_q.link[LNK_RSIZE];
                        w_d.st       = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (wv) begin
                    case (widx)
                        2'd0: w_d.link = wdat;
                        2'd1: if (w_q.upd_base) w_d.base = wdat;
                        default: begin
                            if (w_q.upd_size) w_d.size = wdat;
                            w_d.st = ST_SERVE;
                        end
                    endcase
                end
            end
            default: ;
        endcase

        if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    if (cfg_wdata == '0) begin
                        w_d.st   = ST_IDLE;
                        w_d.done = 1'b0;
                        f_start  = 1'b0;
                        f_abort  = 1'b1;
                    end else if (cfg_wdata[0]) begin
                        w_d.st    = ST_SERVE;
                        w_d.chain = cfg_wdata[1];
                        w_d.err   = 1'b0;
                        w_d.done  = 1'b0;
                        f_start   = 1'b0;
                        f_abort   = 1'b1;
                    end
                end
                REG_LBASE: w_d.lbase = cfg_wdata;
                REG_LINK:  w_d.link  = cfg_wdata;
                REG_BASE:  w_d.base  = cfg_wdata;
                REG_SIZE:  w_d.size  = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= ST_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign buf_req   = (w_q.st == ST_SERVE) && !bad;
    assign buf_addr  = w_q.base;
    assign buf_size  = w_q.size;
    assign buf_last  = is_last;
    assign xfer_done = w_q.done;
    assign err       = w_q.err;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(buf_req && buf_last && buf_done));

    // R3
    serve_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |-> !mem_req);

    // R8
    err_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !buf_req);

    // R2
    single_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && !w_q.chain) |-> buf_last);
endmodule

// File: tb/test_sgw_top.sv
module test_sgw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;
    logic        buf_req;
    logic [31:0] buf_addr;
    logic [31:0] buf_size;
    logic        buf_last;
    logic        buf_done = 1'b0;
    logic        xfer_done;
    logic        err;

    int nchk = 0;
    int nerr = 0;
    int nreads = 0;
    bit ended = 1'b0;
    bit waited = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] mdata [0:255];
    logic [31:0] rlog [0:15];

    always #2 clk = ~clk;

    sgw_top #(.BLK_LOG2(5)) i_sgw_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data), .buf_req(buf_req),
        .buf_addr(buf_addr), .buf_size(buf_size), .buf_last(buf_last),
        .buf_done(buf_done), .xfer_done(xfer_done), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: one wait cycle, then valid for one cycle
    always @(negedge clk) begin
        if (!mem_req || mem_valid) begin
            mem_valid = 1'b0;
            waited = 1'b0;
        end else if (!waited) begin
            waited = 1'b1;
            hold_addr = mem_addr;
        end else begin
            chk("R5 address held", mem_addr, hold_addr);
            mem_data = mdata[mem_addr[9:2]];
            mem_valid = 1'b1;
            if (nreads < 16) rlog[nreads] = mem_addr;
            nreads++;
            waited = 1'b0;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic serve(input string tag, input logic [31:0] a,
                         input logic [31:0] s, input logic last);
        int t = 0;
        while (!buf_req && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " req"}, 32'(buf_req), 32'd1);
        chk({tag, " addr"}, buf_addr, a);
        chk({tag, " size"}, buf_size, s);
        chk({tag, " last"}, 32'(buf_last), 32'(last));
        buf_done = 1'b1;
        @(negedge clk);
        buf_done = 1'b0;
        chk({tag, " R7 done"}, 32'(xfer_done), 32'(last));
        @(negedge clk);
        chk({tag, " R11 pulse"}, 32'(xfer_done), 32'd0);
    endtask

    // expected buffers of the chain: {last, size, addr}
    localparam logic [64:0] EXP_BUF [3] = '{
        {1'b0, 32'd64, 32'h0000_1000},
        {1'b0, 32'd64, 32'h0000_2000},
        {1'b1, 32'd7,  32'h0000_2000}
    };
    localparam logic [31:0] EXP_RD [6] = '{
        32'h10C, 32'h110, 32'h114, 32'h118, 32'h11C, 32'h120
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdata[i] = 32'h0;
        mdata[8'h43] = 32'hC000_0018;
        mdata[8'h44] = 32'h0000_2000;
        mdata[8'h45] = 32'h0000_0999;
        mdata[8'h46] = 32'h0000_0000;
        mdata[8'h47] = 32'h0000_7777;
        mdata[8'h48] = 32'h0000_0007;

        repeat (3) @(negedge clk);
        chk("R1 buf_req in reset", 32'(buf_req), 0);
        chk("R1 mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(xfer_done), 0);
        chk("R1 err after reset", 32'(err), 0);

        // chain walk from the vector table (R3, R4, R6, R7, R9)
        wr(3'd1, 32'h100);
        wr(3'd2, 32'hA000_000C);
        wr(3'd3, 32'h1000);
        wr(3'd4, 32'd64);
        wr(3'd0, 32'h3);
        chk("R3 no read before first buffer", nreads, 0);
        for (int i = 0; i < 3; i++) begin
            serve($sformatf("R6 chain buffer %0d", i), EXP_BUF[i][31:0],
                  EXP_BUF[i][63:32], EXP_BUF[i][64]);
        end
        chk("R4 read count", nreads, 6);
        for (int i = 0; i < 6; i++) chk("R4 read address", rlog[i], EXP_RD[i]);
        repeat (4) @(negedge clk);
        chk("R7 no further read", nreads, 6);

        // single mode
        wr(3'd3, 32'h4000);
        wr(3'd4, 32'd13);
        wr(3'd0, 32'h1);
        serve("R2 single", 32'h4000, 32'd13, 1'b1);
        chk("R2 no read", nreads, 6);

        // misaligned base on a non-last buffer
        wr(3'd2, 32'h8000_0000);
        wr(3'd3, 32'h1002);
        wr(3'd4, 32'd64);
        wr(3'd0, 32'h3);
        @(negedge clk);
        chk("R8 base err", 32'(err), 1);
        chk("R8 base no req", 32'(buf_req), 0);

        // misaligned size on a non-last buffer
        wr(3'd3, 32'h1000);
        wr(3'd4, 32'd40);
        wr(3'd0, 32'h3);
        @(negedge clk);
        chk("R8 size err", 32'(err), 1);
        chk("R8 size no req", 32'(buf_req), 0);

        // last buffer with odd size
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h5000);
        wr(3'd4, 32'd13);
        wr(3'd0, 32'h3);
        chk("R9 err cleared", 32'(err), 0);
        serve("R9 odd last", 32'h5000, 32'd13, 1'b1);

        // stop while serving
        wr(3'd2, 32'h8000_0000);
        wr(3'd3, 32'h1000);
        wr(3'd4, 32'd64);
        wr(3'd0, 32'h3);
        chk("R10 req before stop", 32'(buf_req), 1);
        wr(3'd0, 32'h0);
        chk("R10 req after stop", 32'(buf_req), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 no done", 32'(xfer_done), 0);
        end

        // stop during descriptor fetch
        wr(3'd2, 32'hA000_000C);
        wr(3'd0, 32'h3);
        serve("R10 pre-fetch", 32'h1000, 32'd64, 1'b0);
        chk("R10 fetch running", 32'(mem_req), 1);
        wr(3'd0, 32'h0);
        for (int i = 0; i < 4; i++) begin
            chk("R10 mem_req stopped", 32'(mem_req), 0);
            chk("R10 buf_req stopped", 32'(buf_req), 0);
            @(negedge clk);
        end

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule